// File: doc/BRIEF.md
# Double-Buffered Compare Timer

This block is a 16-bit counter with up to seven compare channels. Every channel keeps two values. The first is a compare register that software writes. The second is a shadow latch, and only the latch takes part in compare matches and in period decisions. Software can therefore stage a new compare value at any time. A per-channel load policy then decides when the staged value becomes active: at the write itself, whenever the counter sits at zero, at an event that depends on the counting mode, or when the channel reaches its own active match.

The counter has four modes. It can stop, count up to the channel 0 latch, run freely with a selectable length, or count up and then down against the channel 0 latch. The counter moves by one on each cycle where `tick` is high. All channel evaluations also happen on tick cycles, and each one uses the counter value held during that cycle. A sticky compare flag for each channel and one sticky overflow flag appear as outputs. Software clears a flag by writing a zero to its bit.

A single-cycle write bus and a combinational read port give access to the control word, the counter, and each channel's control and compare registers.

Top module: `dbt_timer`

## Requirements
- R1: After reset, the control word, the counter, and every channel's control, compare register and latch read as zero, and all flags are low.
- R2: Load policy 0 applies when channel control bits [1:0] are 0. Under this policy, a write to the channel's compare register puts the written value into the latch at the same clock edge.
- R3: Under load policy 1, the latch takes the compare register on every tick where the counter is zero. This happens in every mode, stop mode included.
- R4: Under load policy 2, the latch takes the compare register on a tick at counter zero only when the mode is not stop. In up/down mode it also takes the compare register on a tick where the counter equals the channel's current latch.
- R5: Under load policy 3, the latch takes the compare register on any tick where the counter equals the channel's current latch, in every mode. It is loaded at no other time.
- R6: A tick where the counter equals a channel's latch sets that channel's flag. When a load and a match fall on the same tick, the match uses the latch value from before the load.
- R7: Up mode is mode code 1 (control bits [1:0]). In up mode, a tick with the counter equal to the channel 0 latch makes the next count zero and sets the overflow flag. Any other tick adds one.
- R8: Up/down mode is code 3. On a tick, the counter turns downward when it is at or above the channel 0 latch. It turns upward when it is at zero. A downward step that reaches zero sets the overflow flag.
- R9: Continuous mode is code 2. Its length comes from control bits [3:2]: 0 gives 16 bits, 1 gives 12, 2 gives 10 and 3 gives 8. The counter wraps from the all-ones value of that length to zero and sets the overflow flag.
- R10: The flags are sticky. The overflow flag is control bit 4 and a channel flag is channel control bit 2. Writing 0 to the flag bit clears it and writing 1 leaves it alone. A set on the same cycle wins over the clear.
- R11: Mode 0 is stop. In stop mode, and on cycles without a tick, the counter holds its value. A bus write to the counter wins over counting.
- R12: The address map is: address 0 holds the control word, address 1 the counter, address 2+2i channel i's control, and address 3+2i channel i's compare register. Unused addresses and unused bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable tick for the counter and channel evaluation |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (4) | Register address for writes and reads |
| wdata | input | CW (16) | Write data |
| rdata | output | CW (16) | Combinational read data for `addr` |
| cmp_flag | output | NCH (7) | Sticky compare flag of each channel |
| ovf_flag | output | 1 | Sticky counter overflow flag |

## Verification
A latch that is wrong can never be read back. It shows up only as a compare flag that rises at the wrong count, one cycle after the tick that should or should not have matched. When the channel 0 latch is wrong, the period is wrong as well: the counter wraps or turns at a different count, and the overflow flag moves with it. A bench model of the latches therefore compares the flags on every cycle and reads the counter back often. This exposes a wrong load policy within one counting period of the event that should have loaded the latch.

// File: rtl/dbt_pkg.sv
`timescale 1ns/1ps
package dbt_pkg;
   typedef enum logic [1:0] {
      MODE_STOP = 2'd0,
      MODE_UP   = 2'd1,
      MODE_CONT = 2'd2,
      MODE_UPDN = 2'd3
   } mode_t;

   typedef enum logic [1:0] {
      LD_WRITE = 2'd0,
      LD_ZERO  = 2'd1,
      LD_EVENT = 2'd2,
      LD_MATCH = 2'd3
   } load_t;

   localparam int CTRL_LEN_LSB = 2;
   localparam int CTRL_FLAG_BIT = 4;
   localparam int CH_FLAG_BIT = 2;
endpackage

// File: rtl/dbt_counter.sv
`timescale 1ns/1ps
module dbt_counter
   import dbt_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  mode_t         mode,
   input  logic [1:0]    len_sel,
   input  logic [CW-1:0] period,
   input  logic          wr_cnt,
   input  logic          wr_ctrl,
   input  logic [CW-1:0] wdata,
   output logic [CW-1:0] cnt,
   output logic          ovf
);
   logic [CW-1:0] cnt_n;
   logic [CW-1:0] top_val;
   logic          dir, dir_n, ovf_set;
   int            wid;

   always_comb begin
      case (len_sel)
         2'd0:    wid = CW;
         2'd1:    wid = 12;
         2'd2:    wid = 10;
         default: wid = 8;
      endcase
      if (wid > CW) wid = CW;
      top_val = {CW{1'b1}} >> (CW - wid);
   end

   always_comb begin
      cnt_n   = cnt;
      dir_n   = dir;
      ovf_set = 1'b0;
      if (tick) begin
         unique case (mode)
            MODE_STOP: ;
            MODE_UP: begin
               if (cnt == period) begin
                  cnt_n   = '0;
                  ovf_set = 1'b1;
               end else cnt_n = cnt + 1'b1;
            end
            MODE_CONT: begin
               if (cnt == top_val) begin
                  cnt_n   = '0;
                  ovf_set = 1'b1;
               end else cnt_n = (cnt + 1'b1) & top_val;
            end
            MODE_UPDN: begin
               if (cnt == '0) dir_n = 1'b0;
               else if (cnt >= period) dir_n = 1'b1;
               if (dir_n) begin
                  cnt_n   = cnt - 1'b1;
                  ovf_set = (cnt == CW'(1));
               end else cnt_n = cnt + 1'b1;
            end
         endcase
      end
      if (wr_cnt) cnt_n = wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         dir <= 1'b0;
         ovf <= 1'b0;
      end else begin
         cnt <= cnt_n;
         dir <= dir_n;
         ovf <= (ovf & ~(wr_ctrl & ~wdata[CTRL_FLAG_BIT])) | ovf_set;
      end
   end

   assert_stop_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((!tick || mode == MODE_STOP) && !wr_cnt) |=> $stable(cnt));
   assert_up_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == MODE_UP && cnt == period && !wr_cnt) |=> (cnt == '0 && ovf));
   assert_cont_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == MODE_CONT && len_sel == 2'd3 && cnt == CW'(8'hFF) && !wr_cnt)
      |=> (cnt == '0 && ovf));
   assert_updn_turn_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == MODE_UPDN && cnt != '0 && cnt >= period && !wr_cnt)
      |=> (cnt == $past(cnt) - 1'b1));
   assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !wr_ctrl) |=> ovf);
endmodule

// File: rtl/dbt_channel.sv
`timescale 1ns/1ps
module dbt_channel
   import dbt_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  mode_t         mode,
   input  logic [CW-1:0] cnt,
   input  logic          wr_ctl,
   input  logic          wr_cmp,
   input  logic [CW-1:0] wdata,
   output load_t         pol,
   output logic [CW-1:0] cmp_reg,
   output logic [CW-1:0] latch,
   output logic          flag
);
   logic at_zero, match, running, ev_load, ld;

   assign at_zero = (cnt == '0);
   assign match   = (cnt == latch);
   assign running = (mode != MODE_STOP);

   always_comb begin
      unique case (pol)
         LD_WRITE: ev_load = 1'b0;
         LD_ZERO:  ev_load = at_zero;
         LD_EVENT: ev_load = (at_zero && running) || (mode == MODE_UPDN && match);
         LD_MATCH: ev_load = match;
      endcase
      ld = tick && ev_load;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pol     <= LD_WRITE;
         cmp_reg <= '0;
         latch   <= '0;
         flag    <= 1'b0;
      end else begin
         if (wr_ctl) pol <= load_t'(wdata[1:0]);
         if (wr_cmp) cmp_reg <= wdata;
         if (wr_cmp && pol == LD_WRITE) latch <= wdata;
         else if (ld) latch <= cmp_reg;
         flag <= (flag & ~(wr_ctl & ~wdata[CH_FLAG_BIT])) | (tick & match);
      end
   end

   assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmp && pol == LD_WRITE) |=> (latch == $past(wdata)));
   assert_zero_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == '0 && pol == LD_ZERO && !wr_cmp) |=> (latch == $past(cmp_reg)));
   assert_match_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == latch && pol == LD_MATCH && !wr_cmp) |=> (latch == $past(cmp_reg)));
   assert_latch_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_cmp) |=> $stable(latch));
   assert_match_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == latch) |=> flag);
   assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !wr_ctl) |=> flag);
endmodule

// File: rtl/dbt_timer.sv
`timescale 1ns/1ps
module dbt_timer
   import dbt_pkg::*;
#(
   parameter int NCH = 7,
   parameter int CW  = 16,
   parameter int AW  = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic           wr_en,
   input  logic [AW-1:0]  addr,
   input  logic [CW-1:0]  wdata,
   output logic [CW-1:0]  rdata,
   output logic [NCH-1:0] cmp_flag,
   output logic           ovf_flag
);
   localparam int NREG = 2 * NCH + 2;

   if (NCH < 1 || NCH > 7) begin : g_bad_nch
      $error("dbt_timer: NCH must be 1..7");
   end
   if (CW < 8 || CW > 32) begin : g_bad_cw
      $error("dbt_timer: CW must be 8..32");
   end
   if ((1 << AW) < NREG) begin : g_bad_aw
      $error("dbt_timer: AW too narrow for the register map");
   end

   mode_t         mode;
   logic [1:0]    len_sel;
   logic [CW-1:0] cnt;
   logic          wr_ctrl, wr_cnt;
   logic [CW-1:0] ch_cmp   [NCH];
   logic [CW-1:0] ch_latch [NCH];
   load_t         ch_pol   [NCH];

   assign wr_ctrl = wr_en && (addr == AW'(0));
   assign wr_cnt  = wr_en && (addr == AW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode    <= MODE_STOP;
         len_sel <= 2'd0;
      end else if (wr_ctrl) begin
         mode    <= mode_t'(wdata[1:0]);
         len_sel <= wdata[CTRL_LEN_LSB +: 2];
      end
   end

   dbt_counter #(.CW(CW)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .mode    (mode),
      .len_sel (len_sel),
      .period  (ch_latch[0]),
      .wr_cnt  (wr_cnt),
      .wr_ctrl (wr_ctrl),
      .wdata   (wdata),
      .cnt     (cnt),
      .ovf     (ovf_flag)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic wr_ctl_i, wr_cmp_i;
      assign wr_ctl_i = wr_en && (addr == AW'(2 * i + 2));
      assign wr_cmp_i = wr_en && (addr == AW'(2 * i + 3));
      dbt_channel #(.CW(CW)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick),
         .mode    (mode),
         .cnt     (cnt),
         .wr_ctl  (wr_ctl_i),
         .wr_cmp  (wr_cmp_i),
         .wdata   (wdata),
         .pol     (ch_pol[i]),
         .cmp_reg (ch_cmp[i]),
         .latch   (ch_latch[i]),
         .flag    (cmp_flag[i])
      );
   end

   always_comb begin
      rdata = '0;
      if (addr == AW'(0)) begin
         rdata[1:0]                 = mode;
         rdata[CTRL_LEN_LSB +: 2]   = len_sel;
         rdata[CTRL_FLAG_BIT]       = ovf_flag;
      end else if (addr == AW'(1)) begin
         rdata = cnt;
      end
      for (int i = 0; i < NCH; i++) begin
         if (addr == AW'(2 * i + 2)) begin
            rdata[1:0]         = ch_pol[i];
            rdata[CH_FLAG_BIT] = cmp_flag[i];
         end else if (addr == AW'(2 * i + 3)) begin
            rdata = ch_cmp[i];
         end
      end
   end

   assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == ch_latch[0]) |=> cmp_flag[0]);
   assert_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == MODE_UP && cnt == ch_latch[0] && !wr_en) |=> (cnt == '0));
endmodule

// File: tb/dbt_timer_tb_top.sv
`timescale 1ns/1ps
module dbt_timer_tb_top;
   localparam int NCH = 7;
   localparam int CW  = 16;
   localparam int AW  = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           tick = 1'b0;
   logic           wr_en = 1'b0;
   logic [AW-1:0]  addr = '0;
   logic [CW-1:0]  wdata = '0;
   logic [CW-1:0]  rdata;
   logic [NCH-1:0] cmp_flag;
   logic           ovf_flag;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   int m_cmp [NCH];
   int m_lat [NCH];
   int m_pol [NCH];
   bit m_flag [NCH];
   int m_mode, m_len, m_cnt;
   bit m_dir, m_ovf;

   always #10 clk = ~clk;

   dbt_timer #(.NCH(NCH), .CW(CW), .AW(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
   );

   task automatic chk(string tag, int act, int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int top_of(int len);
      case (len)
         0: return 'hFFFF;
         1: return 'hFFF;
         2: return 'h3FF;
         default: return 'hFF;
      endcase
   endfunction

   // Next-state model written from the requirements
   task automatic model_step(bit w, int a, int d, bit t);
      int nl [NCH];
      bit nf [NCH];
      int cn, top, ci;
      bit dn, ovs, nov, mt, z, ld;
      z = (m_cnt == 0);
      for (int i = 0; i < NCH; i++) begin
         mt = (m_cnt == m_lat[i]);
         case (m_pol[i])
            0: ld = 0;
            1: ld = z;
            2: ld = (z && m_mode != 0) || (m_mode == 3 && mt);
            default: ld = mt;
         endcase
         nl[i] = (t && ld) ? m_cmp[i] : m_lat[i];
         nf[i] = m_flag[i] | (t && mt);
      end
      cn = m_cnt; dn = m_dir; ovs = 0;
      top = top_of(m_len);
      if (t) begin
         case (m_mode)
            1: if (m_cnt == m_lat[0]) begin cn = 0; ovs = 1; end
               else cn = (m_cnt + 1) & 'hFFFF;
            2: if (m_cnt == top) begin cn = 0; ovs = 1; end
               else cn = (m_cnt + 1) & top;
            3: begin
               if (m_cnt == 0) dn = 0;
               else if (m_cnt >= m_lat[0]) dn = 1;
               if (dn) begin cn = m_cnt - 1; ovs = (m_cnt == 1); end
               else cn = (m_cnt + 1) & 'hFFFF;
            end
            default: ;
         endcase
      end
      nov = m_ovf | ovs;
      if (w) begin
         if (a == 0) begin
            m_mode = d & 3;
            m_len  = (d >> 2) & 3;
            nov    = (m_ovf & ((d >> 4) & 1)) | ovs;
         end else if (a == 1) begin
            cn = d & 'hFFFF;
         end else if (a < 2 * NCH + 2) begin
            ci = (a - 2) / 2;
            if (a % 2 == 0) begin
               m_pol[ci] = d & 3;
               nf[ci] = (m_flag[ci] & ((d >> 2) & 1)) | (t && m_cnt == m_lat[ci]);
            end else begin
               m_cmp[ci] = d & 'hFFFF;
               if (m_pol[ci] == 0) nl[ci] = d & 'hFFFF;
            end
         end
      end
      for (int i = 0; i < NCH; i++) begin
         m_lat[i] = nl[i];
         m_flag[i] = nf[i];
      end
      m_cnt = cn; m_dir = dn; m_ovf = nov;
   endtask

   task automatic cyc(bit w, int a, int d, bit t);
      @(negedge clk);
      wr_en = w; addr = a[AW-1:0]; wdata = d[CW-1:0]; tick = t;
      model_step(w, a, d, t);
      @(posedge clk);
      #1;
      wr_en = 1'b0; tick = 1'b0;
   endtask

   task automatic wr(int a, int d); cyc(1, a, d, 0); endtask
   task automatic tk(int n); for (int i = 0; i < n; i++) cyc(0, 0, 0, 1); endtask

   task automatic rd(int a, output int v);
      addr = a[AW-1:0];
      #1;
      v = int'(rdata);
   endtask

   task automatic cmp_model(string tag);
      int v;
      for (int i = 0; i < NCH; i++) chk(tag, int'(cmp_flag[i]), int'(m_flag[i]));
      chk(tag, int'(ovf_flag), int'(m_ovf));
      rd(1, v);
      chk(tag, v, m_cnt);
   endtask

   initial begin
      #(100000 * 20);
      if (!done) begin
         nerr++;
         nchk++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      int v, r, a, d;
      void'($urandom(32'd20240611));
      for (int i = 0; i < NCH; i++) begin
         m_cmp[i] = 0; m_lat[i] = 0; m_pol[i] = 0; m_flag[i] = 0;
      end
      m_mode = 0; m_len = 0; m_cnt = 0; m_dir = 0; m_ovf = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < 2 * NCH + 2; i++) begin
         rd(i, v);
         chk("R1 reset readback", v, 0);
      end
      chk("R1 reset flags", int'(cmp_flag), 0);
      chk("R1 reset ovf", int'(ovf_flag), 0);

      // R2 immediate load, R7 up-mode period, R12 readback
      wr(4, 0); wr(5, 3); wr(3, 6); wr(0, 1);
      rd(0, v); chk("R12 control readback", v, 1);
      rd(5, v); chk("R12 compare readback", v, 3);
      tk(3);
      chk("R2 no match before latch value", int'(cmp_flag[1]), 0);
      tk(1);
      chk("R2 match at written value", int'(cmp_flag[1]), 1);
      tk(2);
      rd(1, v); chk("R7 count before wrap", v, 6);
      chk("R7 ovf before wrap", int'(ovf_flag), 0);
      tk(1);
      rd(1, v); chk("R7 wrap to zero", v, 0);
      chk("R7 ovf set", int'(ovf_flag), 1);

      // R10 sticky flags
      wr(2, 4);
      chk("R10 writing one keeps flag", int'(cmp_flag[0]), 1);
      wr(2, 0);
      chk("R10 writing zero clears flag", int'(cmp_flag[0]), 0);
      wr(0, 1);
      chk("R10 ovf cleared", int'(ovf_flag), 0);

      // R3 zero load in stop mode, R6 pre-load compare, R11 hold
      wr(0, 0); wr(6, 1); wr(7, 2);
      tk(1);
      rd(1, v); chk("R11 stop holds counter", v, 0);
      chk("R6 match uses pre-load latch", int'(cmp_flag[2]), 1);
      wr(6, 1); wr(1, 2);
      chk("R10 cleared before tick", int'(cmp_flag[2]), 0);
      tk(1);
      chk("R3 latch loaded at zero in stop", int'(cmp_flag[2]), 1);

      // R4 no zero load while stopped
      wr(8, 2); wr(9, 2); wr(1, 0);
      tk(1);
      wr(8, 2); wr(1, 2);
      tk(1);
      chk("R4 no load at zero when stopped", int'(cmp_flag[3]), 0);

      // R5 match load
      wr(10, 3); wr(11, 5); wr(1, 0);
      tk(1);
      wr(10, 3); wr(1, 5);
      tk(1);
      chk("R5 latch loaded at own match", int'(cmp_flag[4]), 1);
      wr(12, 3); wr(13, 7); wr(1, 7);
      tk(1);
      chk("R5 no load without match", int'(cmp_flag[5]), 0);

      // R9 continuous 8-bit wrap
      wr(0, 14); wr(1, 'hFE);
      tk(1);
      rd(1, v); chk("R9 reach all ones", v, 'hFF);
      chk("R9 no ovf yet", int'(ovf_flag), 0);
      tk(1);
      rd(1, v); chk("R9 wrap to zero", v, 0);
      chk("R9 ovf set", int'(ovf_flag), 1);

      // R8 up/down
      wr(0, 3); wr(3, 4); wr(1, 0);
      tk(5);
      rd(1, v); chk("R8 turned down at period", v, 3);
      tk(3);
      rd(1, v); chk("R8 reached zero", v, 0);
      chk("R8 ovf at zero", int'(ovf_flag), 1);
      tk(1);
      rd(1, v); chk("R8 turned up at zero", v, 1);
      cmp_model("R6 model after directed");

      // Constrained random phase against the model
      for (int n = 0; n < 4000; n++) begin
         r = $urandom % 10;
         if (r < 6) cyc(0, 0, 0, 1);
         else begin
            a = $urandom % 16;
            case (a)
               0: d = ($urandom % 4) | (($urandom % 4) << 2) | (($urandom % 2) << 4);
               1: d = ($urandom % 8 == 0) ? 'hFFF8 + $urandom % 8 : $urandom % 20;
               default: d = (a % 2 == 0) ? $urandom % 8 : $urandom % 16;
            endcase
            cyc(1, a, d, $urandom % 2);
         end
         for (int i = 0; i < NCH; i++)
            chk("R6 random flag", int'(cmp_flag[i]), int'(m_flag[i]));
         chk("R10 random ovf", int'(ovf_flag), int'(m_ovf));
         if (n % 8 == 0) begin
            rd(1, v);
            chk("R12 random counter", v, m_cnt);
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule